// File: doc/BRIEF.md
# Five-Pin General-Purpose I/O Port

This block gives five chip pins a byte-wide register interface. Software sets the direction of each pin and the value driven on the pins set as outputs. It can also read back a port view in which every bit shows the latched output value for an output pin and the synchronized external level for an input pin. Each pin's output enable follows its direction bit, and its output value follows its data bit.

The block sees two reset classes. The hard class covers power-on and deep hardware standby. It is asynchronous and clears direction and data, so every pin becomes a non-driving input. The retaining class covers manual reset and software standby. It is synchronous and leaves direction and data as they were, so pins keep driving across it. While it is active, bus writes are dropped and the read register shows zero. Pin inputs pass through a two-flop synchronizer before they reach the bus.

Top module: `gpio5_port`

## Requirements
- R1: Direction bit n at 1 sets `pin_oe[n]` to 1, so the pin drives. Direction bit n at 0 sets `pin_oe[n]` to 0, so the pin is an input. The direction register sits at offset 0, and bits 4..0 map to pins 4..0.
- R2: The data register sits at offset 1. A write stores `bus_wdata[4:0]` and drops bits 7..5. A read returns the stored bits with bits 7..5 at 0. `pin_out[n]` equals data bit n.
- R3: While `rst_hard_n` is low, the direction and data registers, the synchronizer and `bus_rdata` are 0. So `pin_oe` and `pin_out` are 0 at once, and reads after release return 0.
- R4: While `rst_keep_n` is low, the direction and data registers keep their value. Bus writes to them are ignored, and `bus_rdata` becomes 0 at the next edge. After release, the registers read back their earlier value.
- R5: The port register at offset 2 is read-only. A write to it changes neither the direction nor the data register, nor the pins.
- R6: A read of offset 2 returns, for each bit n in 4..0, data bit n when direction bit n is 1 and the synchronized pin level when it is 0. Bits 7..5 read 0.
- R7: A change on `pin_in` is sampled by two flops in series. A port read whose capture edge is the third rising edge after the change returns the new level. A read captured on the first or second edge returns the old level.
- R8: Offset 3 is unmapped. A read of it returns 0x00, and a write to it changes nothing.
- R9: `bus_rdata` is loaded at the rising edge where `bus_rd` is 1 and holds until the next read. When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Asynchronous active-low reset for power-on and hardware standby |
| rst_keep_n | input | 1 | Synchronous active-low reset for manual reset and software standby; register contents are retained |
| bus_addr | input | 2 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 5 | External pin levels, asynchronous |
| pin_oe | output | 5 | Per-pin output enable |
| pin_out | output | 5 | Per-pin output value |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a bus read and a bus write to one register. The bench drives both strobes on the data register in a single cycle, expects the value from before the write, and then a second read expects the new one. The second pair is a level change on an input pin and a port read racing the synchronizer. The bench changes `pin_in` in the same cycle as a run of back-to-back port reads, and expects the old level on the first two reads and the new level only on the third.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DIR  = 2'd0,
    OFF_DATA = 2'd1,
    OFF_PORT = 2'd2,
    OFF_NONE = 2'd3
  } reg_off_e;
endpackage

// File: rtl/gpio5_sync.sv
module gpio5_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_hard_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_hard_n) begin
          if (!rst_hard_n) stage_q[0] <= '0;
          else             stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_hard_n) begin
          if (!rst_hard_n) stage_q[s] <= '0;
          else             stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio5_regs.sv
module gpio5_regs
  import gpio5_pkg::*;
#(
  parameter int unsigned NPINS = 5
) (
  input  logic             clk,
  input  logic             rst_hard_n,
  input  logic             rst_keep_n,
  input  logic             wr_en,
  input  reg_off_e         wr_off,
  input  logic [BUS_W-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] data_q
);
  // Named write events, visible to the assertions below
  logic wr_allowed, wr_dir_hit, wr_data_hit;
  assign wr_allowed  = wr_en && rst_keep_n;
  assign wr_dir_hit  = wr_allowed && (wr_off == OFF_DIR);
  assign wr_data_hit = wr_allowed && (wr_off == OFF_DATA);

  generate
    if (NPINS < BUS_W) begin : g_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[BUS_W-1:NPINS];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n)     dir_q <= '0;
    else if (wr_dir_hit) dir_q <= wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n)      data_q <= '0;
    else if (wr_data_hit) data_q <= wdata[NPINS-1:0];
  end

  // R4: the retaining reset keeps both registers
  a_r4_keep_regs: assert property (@(posedge clk) disable iff (!rst_hard_n)
    !rst_keep_n |=> ($stable(dir_q) && $stable(data_q)));
  // R5: writing the port offset touches nothing
  a_r5_port_write_inert: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (wr_en && wr_off == OFF_PORT) |=> ($stable(dir_q) && $stable(data_q)));
  // R8: writing the unmapped offset touches nothing
  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (wr_en && wr_off == OFF_NONE) |=> ($stable(dir_q) && $stable(data_q)));
  // R2: a data write stores the low bits of the bus
  a_r2_data_store: assert property (@(posedge clk) disable iff (!rst_hard_n)
    wr_data_hit |=> (data_q == $past(wdata[NPINS-1:0])));
  // R1: a direction write stores the low bits of the bus
  a_r1_dir_store: assert property (@(posedge clk) disable iff (!rst_hard_n)
    wr_dir_hit |=> (dir_q == $past(wdata[NPINS-1:0])));
endmodule

// File: rtl/gpio5_readmux.sv
module gpio5_readmux
  import gpio5_pkg::*;
#(
  parameter int unsigned NPINS = 5
) (
  input  logic             clk,
  input  logic             rst_hard_n,
  input  logic             rst_keep_n,
  input  logic             rd_en,
  input  reg_off_e         rd_off,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] data_q,
  input  logic [NPINS-1:0] pin_sync,
  output logic [BUS_W-1:0] rdata_q
);
  // Per-bit selection: an output pin reads its latch, an input pin reads its level
  function automatic logic [NPINS-1:0] port_mix(
    input logic [NPINS-1:0] dir,
    input logic [NPINS-1:0] latch,
    input logic [NPINS-1:0] level
  );
    logic [NPINS-1:0] r;
    for (int b = 0; b < NPINS; b++) r[b] = dir[b] ? latch[b] : level[b];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  logic             rd_fire;
  logic [BUS_W-1:0] read_word;

  assign rd_fire = rd_en && rst_keep_n;

  always_comb begin
    unique case (rd_off)
      OFF_DIR:  read_word = widen(dir_q);
      OFF_DATA: read_word = widen(data_q);
      OFF_PORT: read_word = widen(port_mix(dir_q, data_q, pin_sync));
      default:  read_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n)     rdata_q <= '0;
    else if (!rst_keep_n) rdata_q <= '0;
    else if (rd_fire)     rdata_q <= read_word;
  end

  // R6: port bits follow the latch where driven, the level elsewhere
  a_r6_port_mix: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (rd_fire && rd_off == OFF_PORT) |=>
      ((((rdata_q[NPINS-1:0] ^ $past(data_q)) & $past(dir_q)) == '0) &&
       (((rdata_q[NPINS-1:0] ^ $past(pin_sync)) & ~$past(dir_q)) == '0)));
  // R6: reserved bits read zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_hard_n)
    rd_fire |=> ((rdata_q >> NPINS) == '0));
  // R8: unmapped offset reads zero
  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (rd_fire && rd_off == OFF_NONE) |=> (rdata_q == '0));
  // R4: retaining reset blanks the read register
  a_r4_read_blank: assert property (@(posedge clk) disable iff (!rst_hard_n)
    !rst_keep_n |=> (rdata_q == '0));
  // R9: read data holds between reads
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (rst_keep_n && !rd_en) |=> $stable(rdata_q));
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
  import gpio5_pkg::*;
#(
  parameter int unsigned NPINS       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_hard_n,
  input  logic              rst_keep_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out
);
  reg_off_e         off;
  logic [NPINS-1:0] dir_q, data_q, pin_sync;

  assign off = reg_off_e'(bus_addr);

  gpio5_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_hard_n (rst_hard_n),
    .din        (pin_in),
    .dout       (pin_sync)
  );

  gpio5_regs #(.NPINS(NPINS)) u_regs (
    .clk        (clk),
    .rst_hard_n (rst_hard_n),
    .rst_keep_n (rst_keep_n),
    .wr_en      (bus_wr),
    .wr_off     (off),
    .wdata      (bus_wdata),
    .dir_q      (dir_q),
    .data_q     (data_q)
  );

  gpio5_readmux #(.NPINS(NPINS)) u_rmux (
    .clk        (clk),
    .rst_hard_n (rst_hard_n),
    .rst_keep_n (rst_keep_n),
    .rd_en      (bus_rd),
    .rd_off     (off),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .pin_sync   (pin_sync),
    .rdata_q    (bus_rdata)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign pin_oe[p]  = dir_q[p];
      assign pin_out[p] = data_q[p];
    end
  endgenerate

  // R3: hard reset leaves every pin undriven
  a_r3_pins_quiet: assert property (@(posedge clk)
    !rst_hard_n |-> (pin_oe == '0 && pin_out == '0));
  // R1: output enables only move after a bus write
  a_r1_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_hard_n)
    !bus_wr |=> $stable(pin_oe));
endmodule

// File: tb/gpio5_port_tb.sv
module gpio5_port_tb;
  logic       clk = 1'b0;
  logic       rst_hard_n = 1'b0;
  logic       rst_keep_n = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] pin_in = '0;
  logic [4:0] pin_oe, pin_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #2 clk = ~clk;

  gpio5_port u_dut (
    .clk(clk), .rst_hard_n(rst_hard_n), .rst_keep_n(rst_keep_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Bench model of the port view, stated as masks
  function automatic logic [7:0] expect_port(input logic [4:0] d, input logic [4:0] q,
                                             input logic [4:0] lvl);
    return {3'b000, (q & d) | (lvl & ~d)};
  endfunction

  // One bus cycle, called at a falling edge, returns at the next falling edge
  task automatic cyc(input bit wr, input bit rd, input logic [1:0] a, input logic [7:0] wd);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] wd);
    cyc(1'b1, 1'b0, a, wd);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cyc(1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic pins(input string tag, input logic [4:0] oe, input logic [4:0] o);
    chk({tag, " oe"}, {3'b0, pin_oe}, {3'b0, oe});
    chk({tag, " out"}, {3'b0, pin_out}, {3'b0, o});
  endtask

  // Monitor: a read strobe seen at an edge is judged at the next falling edge
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard underflow actual=%02h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pins("R3 during hard reset", 5'h00, 5'h00);
    chk("R3 rdata in reset", bus_rdata, 8'h00);
    rst_hard_n = 1'b1;
    @(negedge clk);
    rd(2'd0, 8'h00, "R3 dir after reset");
    rd(2'd1, 8'h00, "R3 data after reset");

    // R1 / R2: direction and data with reserved bits set in the write
    pin_in = 5'h1A;
    wr(2'd0, 8'hEF);
    wr(2'd1, 8'hF5);
    pins("R1 R2 after writes", 5'h0F, 5'h15);
    rd(2'd0, 8'h0F, "R1 dir readback");
    rd(2'd1, 8'h15, "R2 data readback reserved zero");
    rd(2'd2, expect_port(5'h0F, 5'h15, 5'h1A), "R6 port mix A");

    // R5: write to port offset
    wr(2'd2, 8'hFF);
    pins("R5 pins after port write", 5'h0F, 5'h15);
    rd(2'd0, 8'h0F, "R5 dir unchanged");
    rd(2'd1, 8'h15, "R5 data unchanged");

    // R8: unmapped offset
    wr(2'd3, 8'hFF);
    pins("R8 pins after unmapped write", 5'h0F, 5'h15);
    rd(2'd3, 8'h00, "R8 unmapped read");
    rd(2'd1, 8'h15, "R8 data unchanged");

    // R6 second pattern
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h1F);
    pin_in = 5'h0A;
    repeat (3) @(negedge clk);
    rd(2'd2, expect_port(5'h11, 5'h1F, 5'h0A), "R6 port mix B");

    // R7: synchronizer latency with all pins as inputs
    wr(2'd0, 8'h00);
    pin_in = 5'h00;
    repeat (3) @(negedge clk);
    pin_in = 5'h13;
    rd(2'd2, 8'h00, "R7 edge1 old level");
    rd(2'd2, 8'h00, "R7 edge2 old level");
    rd(2'd2, 8'h13, "R7 edge3 new level");

    // R9: read and write of data in the same cycle
    wr(2'd1, 8'h15);
    exp_q.push_back(8'h15);
    tag_q.push_back("R9 same-cycle read sees old");
    cyc(1'b1, 1'b1, 2'd1, 8'h0A);
    rd(2'd1, 8'h0A, "R9 next read sees new");
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", bus_rdata, 8'h0A);

    // R4: retaining reset
    wr(2'd0, 8'h1F);
    rst_keep_n = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h1F);
    rd(2'd0, 8'h00, "R4 read blank in keep reset");
    pins("R4 pins held in keep reset", 5'h1F, 5'h0A);
    rst_keep_n = 1'b1;
    @(negedge clk);
    rd(2'd0, 8'h1F, "R4 dir retained");
    rd(2'd1, 8'h0A, "R4 data retained");

    // R3: hard reset mid-operation
    rst_hard_n = 1'b0;
    #1;
    pins("R3 async clear", 5'h00, 5'h00);
    @(negedge clk);
    chk("R3 rdata cleared", bus_rdata, 8'h00);
    rst_hard_n = 1'b1;
    @(negedge clk);
    rd(2'd0, 8'h00, "R3 dir cleared");
    rd(2'd1, 8'h00, "R3 data cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule